// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative store that catches lines thrown out of a direct-mapped cache. When the main cache misses, the controller presents the missing line address to the buffer. In the same cycle it also presents the line that the miss will displace from the main cache, if that line is valid. The buffer compares the address against every stored entry at once. A match returns the stored line in the same cycle and keeps the request away from the next memory level. No match raises a forward indication, so the request goes on to the next level.

State changes at the clock edge that ends the probe. On a match, the buffer and the main cache exchange lines: the matching slot receives the displaced line, or empties if the main cache had nothing valid to give up. On a miss, the displaced line is written into the slot that has held its current contents longest among the fills. Whatever that slot held is dropped. Entry tags hold the complete line address, because lines from any main-cache set can share the buffer.

Top module: `vc_victim_buf`

## Requirements
- R1: After reset every entry is invalid, so any probe reports no match until a line has been written in.
- R2: With `req_valid` high and `req_addr` equal to the address of a valid entry, `hit` is 1, `hit_data` carries that entry's line and `miss_fwd` is 0, all in the same cycle.
- R3: With `req_valid` high and no valid entry matching, `hit` is 0 and `miss_fwd` is 1 in the same cycle. With `req_valid` low, both are 0.
- R4: A matching probe with `ev_valid` high writes `ev_addr` and `ev_data` into the matched slot at the clock edge. From the next cycle the probed address no longer matches and the displaced address does.
- R5: A matching probe with `ev_valid` low invalidates the matched slot at the clock edge.
- R6: A non-matching probe with `ev_valid` high writes the displaced line into the slot named by an insertion pointer, then advances the pointer by one, wrapping from ENTRIES-1 to 0. Slots therefore fill in order 0,1,2,3 and are then overwritten in that same order. The line overwritten is discarded.
- R7: A swap (R4) or invalidation (R5) does not move the insertion pointer. A line swapped in keeps the fill age of the slot it lands in.
- R8: With `req_valid` low, `ev_valid`, `ev_addr` and `ev_data` have no effect. A non-matching probe with `ev_valid` low changes no entry.
- R9: Matching compares all LINE_ADDR_W address bits, so addresses that differ only in their upper bits never match each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A main-cache miss is probing the buffer this cycle |
| req_addr | input | LINE_ADDR_W | Line address being probed |
| ev_valid | input | 1 | The main cache is giving up a valid line with this probe |
| ev_addr | input | LINE_ADDR_W | Line address of the displaced line |
| ev_data | input | LINE_W | Contents of the displaced line |
| hit | output | 1 | Probe matched a valid entry |
| hit_data | output | LINE_W | Contents of the matched entry |
| miss_fwd | output | 1 | Probe did not match; send it to the next level |

## Verification
The first probes after reset cover a wide address range and must all miss. Fills longer than the buffer depth show whether the oldest line or some other line gets dropped. Swaps followed by further fills show whether a swapped-in line takes over the age of its slot, and a hit without a displaced line shows that the slot really empties. Addresses that share their low bits but differ in the upper bits catch a comparator narrowed to part of the address. Idle cycles that carry displaced-line data show that nothing is written without a probe. A long pseudo-random run mixes all of these, with a bench model that is kept exclusive from the main cache.

// File: rtl/vc_pkg.sv
package vc_pkg;

   // Operation chosen for one probe cycle
   typedef enum logic [1:0] {
      VC_OP_IDLE = 2'd0,
      VC_OP_SWAP = 2'd1,
      VC_OP_DROP = 2'd2,
      VC_OP_FILL = 2'd3
   } vc_op_e;

   function automatic int unsigned vc_idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/vc_tag_match.sv
module vc_tag_match #(
   parameter int unsigned ENTRIES     = 4,
   parameter int unsigned LINE_ADDR_W = 26
) (
   input  logic [ENTRIES-1:0][LINE_ADDR_W-1:0] tags,
   input  logic [ENTRIES-1:0]                  vld,
   input  logic [LINE_ADDR_W-1:0]              addr,
   output logic [ENTRIES-1:0]                  match
);
   // one full-width comparator per slot
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld[g] && (tags[g] == addr);
   end
endmodule

// File: rtl/vc_hit_encode.sv
module vc_hit_encode #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned IDX_W   = 2
) (
   input  logic [ENTRIES-1:0] match,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      any = |match;
      idx = '0;
      // lowest slot wins if more than one matches
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/vc_line_sel.sv
module vc_line_sel #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned LINE_W  = 128,
   parameter int unsigned IDX_W   = 2,
   parameter bit          AND_OR  = 1'b1
) (
   input  logic [ENTRIES-1:0][LINE_W-1:0] lines,
   input  logic [ENTRIES-1:0]             match,
   input  logic [IDX_W-1:0]               idx,
   output logic [LINE_W-1:0]              line_out
);
   if (AND_OR) begin : g_andor
      // flat AND-OR from the match vector, no encoder on the data path
      always_comb begin
         line_out = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            line_out = line_out | (lines[i] & {LINE_W{match[i]}});
         end
      end
   end else begin : g_index
      // encoded index drives a plain multiplexer
      always_comb begin
         line_out = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            if (idx == IDX_W'(i)) line_out = lines[i];
         end
      end
   end
endmodule

// File: rtl/vc_slot_ptr.sv
module vc_slot_ptr #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned IDX_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (adv) begin
         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   end
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
   parameter int unsigned ENTRIES     = 4,
   parameter int unsigned LINE_ADDR_W = 26,
   parameter int unsigned LINE_W      = 128,
   parameter bit          AND_OR_SEL  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [LINE_ADDR_W-1:0] req_addr,
   input  logic                   ev_valid,
   input  logic [LINE_ADDR_W-1:0] ev_addr,
   input  logic [LINE_W-1:0]      ev_data,
   output logic                   hit,
   output logic [LINE_W-1:0]      hit_data,
   output logic                   miss_fwd
);
   import vc_pkg::*;

   localparam int unsigned IDX_W = vc_idx_w(ENTRIES);

   if (ENTRIES < 2)     begin : g_bad_entries $error("ENTRIES must be at least 2"); end
   if (LINE_ADDR_W < 1) begin : g_bad_addr    $error("LINE_ADDR_W must be at least 1"); end
   if (LINE_W < 1)      begin : g_bad_line    $error("LINE_W must be at least 1"); end

   logic [ENTRIES-1:0][LINE_ADDR_W-1:0] tag_q;
   logic [ENTRIES-1:0][LINE_W-1:0]      data_q;
   logic [ENTRIES-1:0]                  vld_q;
   logic [ENTRIES-1:0]                  match;
   logic                                any_match;
   logic [IDX_W-1:0]                    hit_idx;
   logic [IDX_W-1:0]                    ptr_q;
   vc_op_e                              op;

   vc_tag_match #(.ENTRIES(ENTRIES), .LINE_ADDR_W(LINE_ADDR_W)) u_match (
      .tags  (tag_q),
      .vld   (vld_q),
      .addr  (req_addr),
      .match (match)
   );

   vc_hit_encode #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_enc (
      .match (match),
      .any   (any_match),
      .idx   (hit_idx)
   );

   vc_line_sel #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .IDX_W(IDX_W),
                 .AND_OR(AND_OR_SEL)) u_sel (
      .lines    (data_q),
      .match    (match),
      .idx      (hit_idx),
      .line_out (hit_data)
   );

   vc_slot_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (op == VC_OP_FILL),
      .ptr   (ptr_q)
   );

   assign hit      = req_valid && any_match;
   assign miss_fwd = req_valid && !any_match;

   always_comb begin
      op = VC_OP_IDLE;
      if (req_valid) begin
         if (any_match) op = ev_valid ? VC_OP_SWAP : VC_OP_DROP;
         else if (ev_valid) op = VC_OP_FILL;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         unique case (op)
            VC_OP_SWAP: vld_q[hit_idx] <= 1'b1;
            VC_OP_DROP: vld_q[hit_idx] <= 1'b0;
            VC_OP_FILL: vld_q[ptr_q]   <= 1'b1;
            default:    ;
         endcase
      end
   end

   // line storage carries no reset; validity gates every use
   always_ff @(posedge clk) begin
      if (op == VC_OP_SWAP) begin
         tag_q[hit_idx]  <= ev_addr;
         data_q[hit_idx] <= ev_data;
      end else if (op == VC_OP_FILL) begin
         tag_q[ptr_q]  <= ev_addr;
         data_q[ptr_q] <= ev_data;
      end
   end
endmodule

// File: rtl/vc_victim_buf_chk.sv
module vc_victim_buf_chk #(
   parameter int unsigned ENTRIES     = 4,
   parameter int unsigned LINE_ADDR_W = 26,
   parameter int unsigned LINE_W      = 128,
   parameter int unsigned IDX_W       = 2
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                req_valid,
   input logic [LINE_ADDR_W-1:0]              req_addr,
   input logic                                ev_valid,
   input logic [LINE_ADDR_W-1:0]              ev_addr,
   input logic [LINE_W-1:0]                   ev_data,
   input logic                                hit,
   input logic [LINE_W-1:0]                   hit_data,
   input logic                                miss_fwd,
   input logic [ENTRIES-1:0][LINE_ADDR_W-1:0] tag_q,
   input logic [ENTRIES-1:0][LINE_W-1:0]      data_q,
   input logic [ENTRIES-1:0]                  vld_q,
   input logic [ENTRIES-1:0]                  match,
   input logic [IDX_W-1:0]                    hit_idx,
   input logic [IDX_W-1:0]                    ptr_q
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (vld_q == '0));

   a_r2_hit_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hit) |-> (vld_q[hit_idx] && tag_q[hit_idx] == req_addr
                              && data_q[hit_idx] == hit_data));

   a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   a_r3_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!hit && !miss_fwd));

   a_r4_swap_in: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hit && ev_valid) |=>
         (vld_q[$past(hit_idx)] && tag_q[$past(hit_idx)] == $past(ev_addr)
          && data_q[$past(hit_idx)] == $past(ev_data)));

   a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hit && !ev_valid) |=> !vld_q[$past(hit_idx)]);

   a_r6_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && miss_fwd && ev_valid) |=>
         (vld_q[$past(ptr_q)] && tag_q[$past(ptr_q)] == $past(ev_addr)
          && ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

   a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && miss_fwd && ev_valid) |=> $stable(ptr_q));

   a_r8_no_probe_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(vld_q) && $stable(tag_q) && $stable(data_q)));
endmodule

bind vc_victim_buf vc_victim_buf_chk #(
   .ENTRIES(ENTRIES), .LINE_ADDR_W(LINE_ADDR_W), .LINE_W(LINE_W), .IDX_W(IDX_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data), .hit(hit),
   .hit_data(hit_data), .miss_fwd(miss_fwd), .tag_q(tag_q), .data_q(data_q),
   .vld_q(vld_q), .match(match), .hit_idx(hit_idx), .ptr_q(ptr_q)
);

// File: tb/vc_victim_buf_tb.sv
module vc_victim_buf_tb_top;
   localparam int N  = 4;
   localparam int AW = 10;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          ev_valid = 1'b0;
   logic [AW-1:0] ev_addr = '0;
   logic [DW-1:0] ev_data = '0;
   logic          hit;
   logic [DW-1:0] hit_data;
   logic          miss_fwd;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // bench model of the buffer contents
   logic [AW-1:0] m_tag [N];
   bit            m_v   [N];
   int            m_ptr;
   int            fresh;
   logic [15:0]   lfsr = 16'hACE1;

   always #4 clk = ~clk;

   vc_victim_buf #(.ENTRIES(N), .LINE_ADDR_W(AW), .LINE_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data),
      .hit(hit), .hit_data(hit_data), .miss_fwd(miss_fwd)
   );

   function automatic logic [DW-1:0] dfun(input logic [AW-1:0] a);
      return DW'((32'(a) * 37 + 11) ^ 32'h5A5A);
   endfunction

   function automatic int find(input logic [AW-1:0] a);
      for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == a) return i;
      return -1;
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   // one probe cycle: drive at falling edge, check, then apply model at rising edge
   task automatic op(input bit rv, input logic [AW-1:0] ra, input bit ev,
                     input logic [AW-1:0] ea, input string rq);
      int idx;
      @(negedge clk);
      req_valid = rv; req_addr = ra; ev_valid = ev; ev_addr = ea; ev_data = dfun(ea);
      #1;
      idx = find(ra);
      check(hit == (rv && idx >= 0), rq, "hit", int'(hit), int'(rv && idx >= 0));
      check(miss_fwd == (rv && idx < 0), rq, "miss_fwd", int'(miss_fwd), int'(rv && idx < 0));
      if (rv && idx >= 0)
         check(hit_data == dfun(ra), rq, "hit_data", int'(hit_data), int'(dfun(ra)));
      @(posedge clk);
      if (rv) begin
         if (idx >= 0) begin
            if (ev) m_tag[idx] = ea;
            m_v[idx] = ev;
         end else if (ev) begin
            m_tag[m_ptr] = ea;
            m_v[m_ptr] = 1'b1;
            m_ptr = (m_ptr + 1) % N;
         end
      end
   endtask

   task automatic probe(input logic [AW-1:0] a, input string rq);
      op(1'b1, a, 1'b0, '0, rq);
   endtask

   function automatic logic [AW-1:0] next_fresh();
      fresh++;
      return AW'(fresh);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; end
      m_ptr = 0;
      fresh = 255;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!hit && !miss_fwd, "R3", "outputs in reset", int'(hit) + int'(miss_fwd), 0);
      rst_n = 1'b1;

      // R1: nothing matches after reset
      for (int a = 0; a < 32; a++) probe(AW'(a * 31), "R1");

      // R6: fill past depth, oldest dropped
      for (int i = 0; i < 6; i++) op(1'b1, AW'(900 + i), 1'b1, next_fresh(), "R6");
      for (int i = 256; i <= 261; i++) probe(AW'(i), "R6");

      // R9: same low bits, different upper bits
      op(1'b1, AW'(950), 1'b1, AW'(10'h3C5), "R9");
      probe(AW'(10'h0C5), "R9");
      probe(AW'(10'h1C5), "R9");
      probe(AW'(10'h2C5), "R9");
      probe(AW'(10'h3C5), "R9");

      // R4: swap puts displaced line in matched slot
      begin
         logic [AW-1:0] old_a, new_a;
         old_a = m_tag[2];
         new_a = next_fresh();
         op(1'b1, old_a, 1'b1, new_a, "R4");
         probe(old_a, "R4");
         probe(new_a, "R4");
         // R7: swapped line keeps slot age; further fills follow slot order
         for (int i = 0; i < 4; i++) op(1'b1, AW'(960 + i), 1'b1, next_fresh(), "R7");
         probe(new_a, "R7");
      end

      // R5: hit without a displaced line empties the slot
      begin
         logic [AW-1:0] a;
         a = m_tag[1];
         op(1'b1, a, 1'b0, '0, "R5");
         probe(a, "R5");
         op(1'b1, AW'(970), 1'b1, next_fresh(), "R5");
      end

      // R8: no probe, or miss without displaced line, changes nothing
      begin
         logic [AW-1:0] a;
         a = next_fresh();
         op(1'b0, AW'(0), 1'b1, a, "R8");
         probe(a, "R8");
         op(1'b1, AW'(980), 1'b0, '0, "R8");
         for (int i = 0; i < N; i++) if (m_v[i]) probe(m_tag[i], "R8");
      end

      // R2: mixed pseudo-random sweep
      for (int k = 0; k < 400; k++) begin
         logic [AW-1:0] ra;
         bit rv, ev;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rv = (lfsr[2:0] != 3'd0);
         ev = (lfsr[4:3] != 2'd0);
         if (lfsr[5] && m_v[lfsr[7:6]]) ra = m_tag[lfsr[7:6]];
         else ra = AW'(lfsr[15:8]);
         op(rv, ra, ev, next_fresh(), "R2");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule